// File: doc/BRIEF.md
# Down-Spread Clock Modulation Profile Controller

This controller runs on the reference clock and drives the frequency-offset word of a fractional feedback divider. The clock that divider produces is swept downward from its nominal frequency and never above it. A phase counter moves up and then back down to form a symmetric triangle. The phase is multiplied by a per-step constant, so the sweep reaches the selected depth exactly at its turning point. The modulation period is fixed for each of four input frequency bands and is held in a parameter table. Two depths can be chosen. An active-low enable turns the sweep on; when the enable is inactive the offset is zero.

A rising edge on the restart input returns the sweep to its starting point. The controller also decodes two group-enable pins into an enable mask for six modulated clocks. It has a separate reference enable, which never carries modulation. A change of depth or band is taken up only where a period starts, so the offset never jumps in the middle of a sweep.

Top module: `ssc_profile_ctrl`

## Requirements
- R1: `offset_o` is a signed word in units of 2^-18 of the nominal frequency. It is never positive, and it never goes below minus the full depth of the depth in force (3277 or 9830).
- R2: `wide_sel_i`=0 selects a full depth of 3277 (1.25 %). `wide_sel_i`=1 selects 9830 (3.75 %). Each phase step is worth step = floor(full / half), where half = PERIOD_TAB[band]/2. At the turning point the offset is -half*step.
- R3: While `spread_n_i` is 1 the offset is held at 0 and the sweep is parked at its start. Let j be the number of clock edges since `spread_n_i` went to 0. The offset is then -tri(j)*step.
- R4: The restart input is synchronized. On the fourth clock edge after a rising edge of `restart_i`, the offset becomes 0. The sweep then resumes from its start. A level that stays high causes no further restarts.
- R5: The triangle rises for `half` edges and falls for `half` edges. The offset is 0 again after 2*half edges, and the pattern then repeats with period PERIOD_TAB[`band_sel_i`].
- R6: A change of `wide_sel_i` or `band_sel_i` in the middle of a sweep has no effect until the offset next returns to 0. The next period uses the new step and the new half.
- R7: `clk_en_o[4:0]` are all equal to `oe_main_i`, and `clk_en_o[5]` equals `oe_aux_i`. For {main,aux}: 00 enables none, 01 enables only bit 5, 10 enables only bits 4:0, and 11 enables all six.
- R8: `ref_en_o` is 1 whatever the state of the spread, restart and enable inputs.
- R9: While `rst_ni` is low the offset is 0. The controller works with the idle levels spread on, `wide_sel_i`=1 and `band_sel_i`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_n_i | input | 1 | Sweep enable, active low |
| wide_sel_i | input | 1 | Depth select: 0 gives 1.25 %, 1 gives 3.75 % |
| band_sel_i | input | 2 | Input band select, which chooses the modulation period |
| restart_i | input | 1 | A rising edge restarts the sweep |
| oe_main_i | input | 1 | Enable for modulated clocks 0 to 4 |
| oe_aux_i | input | 1 | Enable for modulated clock 5 |
| offset_o | output | 16 | Signed frequency offset, LSB = 2^-18 |
| clk_en_o | output | 6 | Per-clock enable mask |
| ref_en_o | output | 1 | Enable of the unmodulated reference path |

## Verification
The hardest case to reach is a depth and band change that lands in the middle of a sweep. The old step and the old half must stay in force through the peak and the return to zero, and only then give way. To reach it, the bench parks the sweep with the enable so the phase is known, switches both selects five cycles into the sweep, and follows the offset to the peak and through the whole next period. The restart latency is measured in the same way. The restart is raised at a known phase, and the bench checks the offset on the cycle before the reset of the sweep takes effect and on the cycle after.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned OFFS_W      = 16;
  localparam int unsigned FULL_NARROW = 3277;  // 1.25 % in 2^-18 units
  localparam int unsigned FULL_WIDE   = 9830;  // 3.75 % in 2^-18 units
  localparam int unsigned N_BANDS     = 4;
  localparam int unsigned N_CLK       = 6;

  function automatic int unsigned max_half(input int unsigned tab [N_BANDS]);
    int unsigned m;
    m = 1;
    for (int i = 0; i < N_BANDS; i++)
      if (tab[i] / 2 > m) m = tab[i] / 2;
    return m;
  endfunction
endpackage

// File: rtl/ssc_restart_det.sv
module ssc_restart_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic pulse_o
);
  logic s1_q, s2_q, s2_d_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s2_d_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      s1_q    <= restart_i;
      s2_q    <= s1_q;
      s2_d_q  <= s2_q;
      pulse_q <= s2_q & ~s2_d_q;
    end
  end

  assign pulse_o = pulse_q;

  // R4
  restart_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/ssc_phase_gen.sv
module ssc_phase_gen #(
  parameter int unsigned PH_W = 9,
  parameter int unsigned ST_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PH_W-1:0] half_sel_i,
  input  logic [ST_W-1:0] step_sel_i,
  output logic [PH_W-1:0] phase_o,
  output logic [ST_W-1:0] step_o
);
  logic [PH_W-1:0] phase_q, half_q, half_eff;
  logic [ST_W-1:0] step_q;
  logic            down_q;
  logic            at_start;

  assign at_start = (phase_q == '0);
  // settings are taken up only at the period start
  assign half_eff = at_start ? half_sel_i : half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      down_q  <= 1'b0;
      half_q  <= '0;
      step_q  <= '0;
    end else begin
      if (at_start) begin
        half_q <= half_sel_i;
        step_q <= step_sel_i;
      end
      if (clr_i) begin
        phase_q <= '0;
        down_q  <= 1'b0;
      end else if (!down_q) begin
        phase_q <= phase_q + 1'b1;
        if (PH_W'(phase_q + 1'b1) == half_eff) down_q <= 1'b1;
      end else begin
        phase_q <= phase_q - 1'b1;
        if (phase_q == PH_W'(1)) down_q <= 1'b0;
      end
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;

  // R5
  phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_start |-> phase_q <= half_q);
  // R5
  peak_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_start && phase_q == half_q && !clr_i) |=> phase_q == $past(phase_q) - 1'b1);
  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_start |=> $stable(step_q));
endmodule

// File: rtl/ssc_depth_scale.sv
module ssc_depth_scale #(
  parameter int unsigned PH_W = 9,
  parameter int unsigned ST_W = 16
) (
  input  logic [PH_W-1:0]       phase_i,
  input  logic [ST_W-1:0]       step_i,
  output logic signed [ST_W-1:0] offset_o
);
  logic [ST_W-1:0] mag;

  // phase <= half and step <= full/half, so the product fits
  assign mag      = ST_W'(32'(phase_i) * 32'(step_i));
  assign offset_o = -$signed(mag);
endmodule

// File: rtl/ssc_oe_decode.sv
module ssc_oe_decode #(
  parameter int unsigned N_CLK = 6
) (
  input  logic             oe_main_i,
  input  logic             oe_aux_i,
  output logic [N_CLK-1:0] clk_en_o
);
  for (genvar i = 0; i < N_CLK; i++) begin : g_en
    if (i == N_CLK - 1) begin : g_aux
      assign clk_en_o[i] = oe_aux_i;
    end else begin : g_main
      assign clk_en_o[i] = oe_main_i;
    end
  end
endmodule

// File: rtl/ssc_profile_ctrl.sv
module ssc_profile_ctrl
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD_TAB [N_BANDS] = '{992, 1000, 1008, 1016}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     spread_n_i,
  input  logic                     wide_sel_i,
  input  logic [1:0]               band_sel_i,
  input  logic                     restart_i,
  input  logic                     oe_main_i,
  input  logic                     oe_aux_i,
  output logic signed [OFFS_W-1:0] offset_o,
  output logic [N_CLK-1:0]         clk_en_o,
  output logic                     ref_en_o
);
  localparam int unsigned MAX_HALF = max_half(PERIOD_TAB);
  localparam int unsigned PH_W     = $clog2(MAX_HALF + 1);

  logic [OFFS_W-1:0] step_tab [2*N_BANDS];
  logic [PH_W-1:0]   half_tab [N_BANDS];
  logic              rst_pulse, clr;
  logic [PH_W-1:0]   phase;
  logic [OFFS_W-1:0] step;

  for (genvar b = 0; b < N_BANDS; b++) begin : g_band
    localparam int unsigned HALF = PERIOD_TAB[b] / 2;
    assign half_tab[b]           = PH_W'(HALF);
    assign step_tab[b]           = OFFS_W'(FULL_NARROW / HALF);
    assign step_tab[N_BANDS + b] = OFFS_W'(FULL_WIDE / HALF);
  end

  ssc_restart_det u_restart (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .pulse_o  (rst_pulse)
  );

  assign clr = spread_n_i | rst_pulse;

  ssc_phase_gen #(.PH_W(PH_W), .ST_W(OFFS_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .half_sel_i(half_tab[band_sel_i]),
    .step_sel_i(step_tab[{wide_sel_i, band_sel_i}]),
    .phase_o   (phase),
    .step_o    (step)
  );

  ssc_depth_scale #(.PH_W(PH_W), .ST_W(OFFS_W)) u_scale (
    .phase_i (phase),
    .step_i  (step),
    .offset_o(offset_o)
  );

  ssc_oe_decode #(.N_CLK(N_CLK)) u_oe (
    .oe_main_i(oe_main_i),
    .oe_aux_i (oe_aux_i),
    .clk_en_o (clk_en_o)
  );

  assign ref_en_o = 1'b1;

  // R1
  offset_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_o <= 0 && offset_o >= -$signed(OFFS_W'(FULL_WIDE)));
  // R3
  spread_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spread_n_i |=> offset_o == '0);
  // R4
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse |=> offset_o == '0);
endmodule

// File: tb/ssc_profile_ctrl_tb.sv
module ssc_profile_ctrl_tb_top;
  localparam int unsigned PER [4] = '{40, 60, 80, 100};
  localparam int FULL_N = 3277;
  localparam int FULL_W = 9830;
  // {main, aux, wide, band[1:0], expected mask[5:0]}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 2'd3, 6'b111111},
    {1'b0, 1'b0, 1'b0, 2'd0, 6'b000000},
    {1'b0, 1'b1, 1'b1, 2'd0, 6'b100000},
    {1'b1, 1'b0, 1'b0, 2'd1, 6'b011111},
    {1'b1, 1'b1, 1'b0, 2'd2, 6'b111111},
    {1'b0, 1'b1, 1'b0, 2'd3, 6'b100000},
    {1'b1, 1'b0, 1'b1, 2'd1, 6'b011111},
    {1'b1, 1'b1, 1'b1, 2'd2, 6'b111111}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic spread_n, wide, restart, oe_main, oe_aux;
  logic [1:0] band;
  logic signed [15:0] offset;
  logic [5:0] clk_en;
  logic ref_en;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  ssc_profile_ctrl #(.PERIOD_TAB(PER)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .spread_n_i(spread_n), .wide_sel_i(wide),
    .band_sel_i(band), .restart_i(restart), .oe_main_i(oe_main), .oe_aux_i(oe_aux),
    .offset_o(offset), .clk_en_o(clk_en), .ref_en_o(ref_en)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int step_of(input logic w, input logic [1:0] b);
    return (w ? FULL_W : FULL_N) / int'(PER[b] / 2);
  endfunction

  task automatic park_and_start();
    spread_n = 1'b1;
    ticks(2);
    check("R3 parked", int'(offset), 0);
    spread_n = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    spread_n = 1'b0; wide = 1'b1; band = 2'd3; restart = 1'b0;
    oe_main = 1'b1; oe_aux = 1'b1;
    ticks(3);
    check("R9 reset offset", int'(offset), 0);
    check("R8 reset ref", int'(ref_en), 1);
    rst_ni = 1'b1;
    // R9: idle defaults run the sweep
    begin
      int s = step_of(1'b1, 2'd3);
      ticks(1);
      check("R9 default first step", int'(offset), -s);
    end

    for (int i = 0; i < 8; i++) begin
      int h, s;
      {oe_main, oe_aux, wide, band} = VEC[i][10:6];
      h = int'(PER[band] / 2);
      s = step_of(wide, band);
      park_and_start();
      check("R7 enable mask", int'(clk_en), int'(VEC[i][5:0]));
      check("R8 ref enable", int'(ref_en), 1);
      ticks(1);
      check("R3 first step", int'(offset), -s);
      ticks(h - 1);
      check("R2 peak", int'(offset), -h * s);
      check("R1 within depth", int'(offset >= -(wide ? FULL_W : FULL_N)), 1);
      ticks(h);
      check("R5 period end", int'(offset), 0);
      ticks(1);
      check("R5 repeat", int'(offset), -s);
    end

    // R4: restart latency and edge-only behaviour
    wide = 1'b0; band = 2'd0;
    park_and_start();
    ticks(5);
    restart = 1'b1;
    ticks(3);
    check("R4 before effect", int'(offset), -8 * 163);
    ticks(1);
    check("R4 restart zero", int'(offset), 0);
    ticks(1);
    check("R4 resume", int'(offset), -163);
    ticks(3);
    check("R4 held level", int'(offset), -4 * 163);
    restart = 1'b0;

    // R6: mid-sweep select change waits for the period start
    park_and_start();
    ticks(5);
    wide = 1'b1; band = 2'd1;
    ticks(1);
    check("R6 old step kept", int'(offset), -6 * 163);
    ticks(14);
    check("R6 old peak", int'(offset), -20 * 163);
    ticks(20);
    check("R6 old period end", int'(offset), 0);
    ticks(1);
    check("R6 new step", int'(offset), -327);
    ticks(29);
    check("R6 new peak", int'(offset), -30 * 327);
    ticks(30);
    check("R6 new period end", int'(offset), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule